// File: doc/BRIEF.md
# Stop Clock Request Handler

This block accepts an asynchronous, active-low request to stop the processor input clock and brings the core to a clean, quiescent point before that clock may be gated. The request is first brought into the clock domain through a short flip-flop chain. Once it is recognised, the block waits for the next instruction boundary. It does not take a boundary at which a higher-priority interrupt is pending, because the interrupt wins there.

At an accepted boundary the block asserts a halt-issue signal and a drain request. It holds both until the pipeline and the write buffers both report empty. It then raises a one-cycle request for the stop-grant special bus cycle. When the bus answers with ready, or with burst-ready in the default variant, the block reports that the core is stopped. It stays stopped until the requester withdraws the request.

If the request is withdrawn before the acknowledge arrives, the block drops back to idle and pulses a protocol-error flag. Gating the clock is left to the surrounding logic.

Top module: `stopclk_ctrl`

## Requirements
- R1: `stop_req_n` is active low and passes through `SYNC_STAGES` flip-flops (default 2) before it is used. With `insn_boundary` already high and `irq_pending` low, a request driven low between two edges raises `drain_req` on the (`SYNC_STAGES`+2)-th rising edge that follows.
- R2: After recognition, nothing leaves idle-looking output (all outputs 0) until an edge at which `insn_boundary` is 1.
- R3: An edge at which `insn_boundary` is 1 but `irq_pending` is 1 is not taken as the stopping point. The block keeps waiting with all outputs 0.
- R4: From the accepted boundary, `halt_issue` and `drain_req` are 1, and `drain_req` stays 1 until an edge at which `pipe_empty` and `wbuf_empty` are both 1.
- R5: The edge that sees both empty flags high makes `spc_req` 1 for exactly one cycle, with `halt_issue` 1 and `drain_req` 0.
- R6: After the special cycle is requested, `stopped` becomes 1 on the first edge with `bus_rdy` high, or with `bus_brdy` high when `ACCEPT_BURST_ACK`=1. With `ACCEPT_BURST_ACK`=0, `bus_brdy` alone does not complete the stop.
- R7: Withdrawing the request (synchronised `stop_req_n` high) at any point after recognition and before the acknowledge returns the block to idle. `proto_err` is 1 for exactly one cycle and all other outputs are 0.
- R8: In the stopped state, withdrawing the request returns all outputs to 0 with `proto_err` staying 0. `stopped` and `halt_issue` remain 1 until the synchronised release is seen.
- R9: While `rst_n` is low, every output is 0 and the synchroniser holds the request inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_req_n | input | 1 | Asynchronous active-low stop-clock request |
| insn_boundary | input | 1 | High in a cycle that is an instruction boundary |
| irq_pending | input | 1 | High while a higher-priority interrupt is pending |
| pipe_empty | input | 1 | Pipeline holds no work |
| wbuf_empty | input | 1 | Write buffers hold no data |
| bus_rdy | input | 1 | Bus ready acknowledge |
| bus_brdy | input | 1 | Bus burst-ready acknowledge |
| halt_issue | output | 1 | Stop issuing new instructions |
| drain_req | output | 1 | Request to empty pipeline and write buffers |
| spc_req | output | 1 | One-cycle request for the stop-grant special bus cycle |
| stopped | output | 1 | Core is stopped and the clock may be gated |
| proto_err | output | 1 | One-cycle pulse: request withdrawn before acknowledge |

## Verification
The assertions cover the properties that hold on every cycle. At most one of drain, special-cycle and stopped is active at any time. The special-cycle pulse lasts one cycle and always follows draining. Draining starts only at a boundary with no pending interrupt, and it persists while either empty flag is low. Stopped rises only after an acknowledge, and the error pulse occurs only with halt released. Only the bench's scenarios show the rest: the exact recognition latency through the synchroniser, the sweep over boundary, drain and acknowledge delays, burst-ready being ignored in the restricted variant, and the release paths out of each state.

// File: rtl/stopclk_pkg.sv
package stopclk_pkg;
   typedef enum logic [2:0] {
      ST_IDLE     = 3'd0,
      ST_WAIT_BND = 3'd1,
      ST_DRAIN    = 3'd2,
      ST_ISSUE    = 3'd3,
      ST_WAIT_ACK = 3'd4,
      ST_STOPPED  = 3'd5
   } stop_state_e;
endpackage

// File: rtl/stopclk_sync.sv
module stopclk_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_n,
   output logic sync_n
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("stopclk_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-2:0], async_n};
   end

   assign sync_n = chain[STAGES-1];
endmodule

// File: rtl/stopclk_ack_sel.sv
module stopclk_ack_sel #(
   parameter bit ACCEPT_BURST = 1'b1
) (
   input  logic rdy_i,
   input  logic brdy_i,
   output logic ack_o
);
   generate
      if (ACCEPT_BURST) begin : g_both
         assign ack_o = rdy_i | brdy_i;
      end else begin : g_rdy_only
         assign ack_o = rdy_i | (brdy_i & 1'b0);
      end
   endgenerate
endmodule

// File: rtl/stopclk_fsm.sv
module stopclk_fsm
   import stopclk_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic req_act,
   input  logic boundary,
   input  logic irq,
   input  logic pipe_mt,
   input  logic wbuf_mt,
   input  logic ack,
   output logic halt_o,
   output logic drain_o,
   output logic cyc_o,
   output logic stop_o,
   output logic err_o
);
   stop_state_e state, state_nxt;
   logic        err_nxt;

   always_comb begin
      state_nxt = state;
      err_nxt   = 1'b0;
      unique case (state)
         ST_IDLE:     if (req_act) state_nxt = ST_WAIT_BND;
         ST_WAIT_BND: if (boundary && !irq) state_nxt = ST_DRAIN;
         ST_DRAIN:    if (pipe_mt && wbuf_mt) state_nxt = ST_ISSUE;
         ST_ISSUE:    state_nxt = ST_WAIT_ACK;
         ST_WAIT_ACK: if (ack) state_nxt = ST_STOPPED;
         ST_STOPPED:  if (!req_act) state_nxt = ST_IDLE;
         default:     state_nxt = ST_IDLE;
      endcase
      if (!req_act && state != ST_IDLE && state != ST_STOPPED) begin
         state_nxt = ST_IDLE;
         err_nxt   = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         err_o <= 1'b0;
      end else begin
         state <= state_nxt;
         err_o <= err_nxt;
      end
   end

   assign drain_o = (state == ST_DRAIN);
   assign cyc_o   = (state == ST_ISSUE);
   assign stop_o  = (state == ST_STOPPED);
   assign halt_o  = drain_o || cyc_o || stop_o || (state == ST_WAIT_ACK);
endmodule

// File: rtl/stopclk_ctrl.sv
module stopclk_ctrl #(
   parameter int SYNC_STAGES      = 2,
   parameter bit ACCEPT_BURST_ACK = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic stop_req_n,
   input  logic insn_boundary,
   input  logic irq_pending,
   input  logic pipe_empty,
   input  logic wbuf_empty,
   input  logic bus_rdy,
   input  logic bus_brdy,
   output logic halt_issue,
   output logic drain_req,
   output logic spc_req,
   output logic stopped,
   output logic proto_err
);
   logic req_sync_n;
   logic ack;

   stopclk_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .async_n(stop_req_n), .sync_n(req_sync_n)
   );

   stopclk_ack_sel #(.ACCEPT_BURST(ACCEPT_BURST_ACK)) u_ack (
      .rdy_i(bus_rdy), .brdy_i(bus_brdy), .ack_o(ack)
   );

   stopclk_fsm u_fsm (
      .clk(clk), .rst_n(rst_n), .req_act(!req_sync_n),
      .boundary(insn_boundary), .irq(irq_pending),
      .pipe_mt(pipe_empty), .wbuf_mt(wbuf_empty), .ack(ack),
      .halt_o(halt_issue), .drain_o(drain_req), .cyc_o(spc_req),
      .stop_o(stopped), .err_o(proto_err)
   );
endmodule

// File: rtl/stopclk_ctrl_chk.sv
module stopclk_ctrl_chk (
   input logic clk,
   input logic rst_n,
   input logic insn_boundary,
   input logic irq_pending,
   input logic pipe_empty,
   input logic wbuf_empty,
   input logic bus_rdy,
   input logic bus_brdy,
   input logic halt_issue,
   input logic drain_req,
   input logic spc_req,
   input logic stopped,
   input logic proto_err
);
   p_excl_phase_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({drain_req, spc_req, stopped}));

   p_bnd_no_irq_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(drain_req) |-> $past(insn_boundary && !irq_pending));

   p_drain_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (drain_req && !(pipe_empty && wbuf_empty)) |=> (drain_req || proto_err));

   p_cyc_after_drain_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(spc_req) |-> $past(drain_req && pipe_empty && wbuf_empty));

   p_cyc_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
      spc_req |=> !spc_req);

   p_stop_on_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stopped) |-> $past(bus_rdy || bus_brdy));

   p_err_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      proto_err |-> (!halt_issue && !stopped));

   p_err_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      proto_err |=> !proto_err);
endmodule

bind stopclk_ctrl stopclk_ctrl_chk u_chk (
   .clk(clk), .rst_n(rst_n), .insn_boundary(insn_boundary),
   .irq_pending(irq_pending), .pipe_empty(pipe_empty), .wbuf_empty(wbuf_empty),
   .bus_rdy(bus_rdy), .bus_brdy(bus_brdy), .halt_issue(halt_issue),
   .drain_req(drain_req), .spc_req(spc_req), .stopped(stopped),
   .proto_err(proto_err)
);

// File: tb/tb_stopclk_ctrl.sv
`timescale 1ns/100ps
module tb_stopclk_ctrl;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_n = 1'b1, bnd = 1'b0, irq = 1'b0, pe = 1'b0, we = 1'b0;
   logic rdy = 1'b0, brdy = 1'b0;
   logic halt, drain, spc, stp, err;
   logic halt_b, drain_b, spc_b, stp_b, err_b;
   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   stopclk_ctrl dut (
      .clk(clk), .rst_n(rst_n), .stop_req_n(req_n), .insn_boundary(bnd),
      .irq_pending(irq), .pipe_empty(pe), .wbuf_empty(we), .bus_rdy(rdy),
      .bus_brdy(brdy), .halt_issue(halt), .drain_req(drain), .spc_req(spc),
      .stopped(stp), .proto_err(err)
   );

   stopclk_ctrl #(.ACCEPT_BURST_ACK(1'b0)) dut_nb (
      .clk(clk), .rst_n(rst_n), .stop_req_n(req_n), .insn_boundary(bnd),
      .irq_pending(irq), .pipe_empty(pe), .wbuf_empty(we), .bus_rdy(rdy),
      .bus_brdy(brdy), .halt_issue(halt_b), .drain_req(drain_b), .spc_req(spc_b),
      .stopped(stp_b), .proto_err(err_b)
   );

   // packed view: {halt_issue, drain_req, spc_req, stopped, proto_err}
   task automatic tick();
      @(posedge clk); #1;
   endtask

   task automatic chk(string tag, logic [4:0] got, logic [4:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %b expected %b", tag, got, exp);
      end
   endtask

   function automatic logic [4:0] o_a();
      return {halt, drain, spc, stp, err};
   endfunction
   function automatic logic [4:0] o_b();
      return {halt_b, drain_b, spc_b, stp_b, err_b};
   endfunction

   task automatic run_stop(int bd, int dd, int ad, bit use_b);
      bnd = 0; irq = 0; pe = 0; we = 0; rdy = 0; brdy = 0;
      req_n = 0;
      repeat (3) tick();
      chk("R1 recognised, waiting", o_a(), 5'b00000);
      for (int i = 0; i < bd; i++) begin
         tick(); chk("R2 no boundary yet", o_a(), 5'b00000);
      end
      bnd = 1;
      tick(); chk("R1/R2 drain at boundary", o_a(), 5'b11000);
      for (int i = 0; i < dd; i++) begin
         tick(); chk("R4 draining", o_a(), 5'b11000);
      end
      pe = 1; we = 1;
      tick(); chk("R5 special cycle", o_a(), 5'b10100);
      bnd = 0;
      tick(); chk("R5 single pulse", o_a(), 5'b10000);
      for (int i = 0; i < ad; i++) begin
         tick(); chk("R6 awaiting ack", o_a(), 5'b10000);
      end
      if (use_b) brdy = 1; else rdy = 1;
      tick(); chk("R6 stopped after ack", o_a(), 5'b10010);
      if (use_b) chk("R6 brdy ignored in rdy-only", o_b(), 5'b10000);
      else       chk("R6 rdy-only variant", o_b(), 5'b10010);
      rdy = 0; brdy = 0; pe = 0; we = 0;
      req_n = 1;
      repeat (2) tick();
      chk("R8 held until sync release", o_a(), 5'b10010);
      tick(); chk("R8 released cleanly", o_a(), 5'b00000);
      if (use_b) chk("R7 withdraw while awaiting ack", o_b(), 5'b00001);
      tick();
   endtask

   initial begin
      repeat (3) tick();
      chk("R9 reset outputs", o_a(), 5'b00000);
      req_n = 0;
      repeat (4) tick();
      chk("R9 request held off in reset", o_a(), 5'b00000);
      req_n = 1;
      rst_n = 1;
      repeat (3) tick();
      chk("R9 idle after reset", o_a(), 5'b00000);

      // near-exhaustive sweep of delays and ack types
      for (int bd = 0; bd < 3; bd++)
         for (int dd = 0; dd < 3; dd++)
            for (int ad = 0; ad < 3; ad++)
               run_stop(bd, dd, ad, ((bd + dd + ad) % 2) == 1);

      // interrupt supersedes boundary, then partial empties
      req_n = 0; bnd = 1; irq = 1;
      repeat (3) tick();
      for (int i = 0; i < 4; i++) begin
         tick(); chk("R3 interrupt wins boundary", o_a(), 5'b00000);
      end
      irq = 0;
      tick(); chk("R3 boundary after interrupt", o_a(), 5'b11000);
      pe = 1; we = 0;
      tick(); chk("R4 wbuf not empty", o_a(), 5'b11000);
      pe = 0; we = 1;
      tick(); chk("R4 pipe not empty", o_a(), 5'b11000);
      pe = 0; we = 0;
      // withdraw during drain
      req_n = 1;
      repeat (2) tick();
      chk("R7 still draining before sync", o_a(), 5'b11000);
      tick(); chk("R7 abort from drain", o_a(), 5'b00001);
      tick(); chk("R7 error one cycle", o_a(), 5'b00000);

      // withdraw while waiting for boundary
      bnd = 0; req_n = 0;
      repeat (3) tick();
      req_n = 1;
      repeat (2) tick();
      chk("R7 waiting before sync", o_a(), 5'b00000);
      tick(); chk("R7 abort from wait", o_a(), 5'b00001);
      tick(); chk("R7 error cleared", o_a(), 5'b00000);

      // reset in the middle of draining
      req_n = 0; bnd = 1;
      repeat (4) tick();
      chk("R4 drain before reset", o_a(), 5'b11000);
      rst_n = 0; #1;
      chk("R9 async reset clears", o_a(), 5'b00000);
      req_n = 1; bnd = 0;
      tick(); rst_n = 1;
      repeat (3) tick();
      chk("R9 idle after second reset", o_a(), 5'b00000);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule